// File: doc/BRIEF.md
# Fully Associative Translation Buffer with Table Reload

This block caches virtual-page to physical-frame translations in a small set of slots that are all searched at once. A lookup presents a full virtual address together with an access kind (read or write). When the page field matches a valid slot, the block answers with the cached frame joined to the untouched low offset bits. It also records in that slot that the page was referenced and, for writes, that it was modified.

When no slot matches, the block fetches the page's table entry over a request/valid handshake. A table entry marked not present ends the lookup with a page fault and changes nothing. A present entry is written into a victim slot and the lookup completes with the new frame. A slot that is empty is always chosen before an occupied one. When an occupied slot is displaced, its modified and referenced flags are sent back to the page table on a write-back strobe so that they are not lost. A single-cycle flush input empties every slot.

Top module: `tlb_xlate`

## Requirements
- R1: After reset no slot holds a translation, `req_ready_o` is 1, and `resp_valid_o`, `resp_fault_o`, `pt_req_o` and `wb_strobe_o` are 0. The first lookup of any page therefore misses.
- R2: A lookup is accepted at a rising edge where `req_valid_i` and `req_ready_o` are both 1. The page field is `req_vaddr_i[31:12]` and the offset is `req_vaddr_i[11:0]`. If a valid slot holds that page, `resp_valid_o` is 1 for the single following cycle with `resp_paddr_o = {frame, offset}` and `resp_fault_o = 0`, and `pt_req_o` stays 0.
- R3: If no valid slot holds the page, `pt_req_o` rises in the cycle after acceptance with `pt_vpn_o` equal to the page field. Both hold steady, and `req_ready_o` stays 0, until an edge where `pt_valid_i` is 1.
- R4: At an edge with `pt_req_o` and `pt_valid_i` both 1 and `pt_present_i = 1`, the block answers one cycle later with `resp_paddr_o = {pt_pfn_i, offset}` and `resp_fault_o = 0`. Later lookups of that page then hit.
- R5: At an edge with `pt_req_o` and `pt_valid_i` both 1 and `pt_present_i = 0`, the block answers one cycle later with `resp_valid_o = 1` and `resp_fault_o = 1`, and with no write-back strobe. Nothing is installed, so a repeated lookup of the same page misses again.
- R6: A read hit sets the slot's referenced flag. A write hit sets both the referenced and the modified flag. An installed slot starts with the referenced flag set and the modified flag equal to `pt_dirty_i` OR (the access is a write).
- R7: The victim is the lowest-numbered empty slot if one exists. Otherwise it is the slot named by a round-robin pointer that starts at 0 after reset and advances by one, modulo the slot count, each time an occupied slot is displaced.
- R8: When an occupied slot is displaced, `wb_strobe_o` is 1 in the same cycle as the response. In that cycle `wb_vpn_o`, `wb_dirty_o` and `wb_ref_o` carry the displaced slot's page, modified flag and referenced flag. Filling an empty slot gives no strobe.
- R9: `flush_i` high at a rising edge empties every slot by the next cycle, so every later lookup misses until it is reloaded. The round-robin pointer is left unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush_i | input | 1 | Empty every slot |
| req_valid_i | input | 1 | Lookup request |
| req_ready_o | output | 1 | Block can accept a lookup |
| req_write_i | input | 1 | 1 = write access, 0 = read access |
| req_vaddr_i | input | 32 | Virtual address: page field above the offset |
| resp_valid_o | output | 1 | One-cycle response pulse |
| resp_fault_o | output | 1 | Response is a page fault |
| resp_paddr_o | output | 32 | Physical address: frame above the offset |
| pt_req_o | output | 1 | Page-table read request |
| pt_vpn_o | output | 20 | Page being fetched |
| pt_valid_i | input | 1 | Page-table entry returned |
| pt_present_i | input | 1 | Returned entry is present |
| pt_pfn_i | input | 20 | Returned frame number |
| pt_dirty_i | input | 1 | Returned entry's modified flag |
| wb_strobe_o | output | 1 | Usage write-back for a displaced slot |
| wb_vpn_o | output | 20 | Page of the displaced slot |
| wb_dirty_o | output | 1 | Modified flag of the displaced slot |
| wb_ref_o | output | 1 | Referenced flag of the displaced slot |

## Verification
A hit answers exactly one cycle after the accepting edge, and a miss raises the table request in that same cycle instead. The fill response and any write-back strobe both appear one cycle after the edge that samples the returned entry. The bench drives inputs on falling edges and samples on the falling edge that follows the edge which should have produced each result. A wrong result and a late result both show up as mismatches. A running model of slot contents, flags and the round-robin pointer predicts hit or miss, the victim page and its flags for every lookup in ordered and pseudo-random sweeps.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    localparam int unsigned DEF_ENTRIES = 8;
    localparam int unsigned DEF_VPN_W   = 20;
    localparam int unsigned DEF_OFF_W   = 12;
    localparam int unsigned DEF_PFN_W   = 20;

    typedef enum logic [0:0] {
        CTL_IDLE = 1'b0,
        CTL_WALK = 1'b1
    } ctl_state_e;

    typedef struct packed {
        logic valid;
        logic dirty;
        logic refd;
    } usage_t;

    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/tlb_cam.sv
module tlb_cam
    import tlb_pkg::*;
#(
    parameter int unsigned ENTRIES = DEF_ENTRIES,
    parameter int unsigned VPN_W   = DEF_VPN_W,
    parameter int unsigned PFN_W   = DEF_PFN_W,
    parameter int unsigned IDX_W   = idx_width(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               flush,
    input  logic [VPN_W-1:0]   lk_vpn,
    input  logic               touch_en,
    input  logic               touch_write,
    output logic               hit,
    output logic [PFN_W-1:0]   hit_pfn,
    input  logic               fill_en,
    input  logic [IDX_W-1:0]   fill_idx,
    input  logic [VPN_W-1:0]   fill_vpn,
    input  logic [PFN_W-1:0]   fill_pfn,
    input  logic               fill_dirty,
    input  logic [IDX_W-1:0]   vic_idx,
    output logic [VPN_W-1:0]   vic_vpn,
    output usage_t             vic_use,
    output logic [ENTRIES-1:0] valid_vec
);

    logic [ENTRIES-1:0]            match;
    logic [ENTRIES-1:0][VPN_W-1:0] tag_all;
    logic [ENTRIES-1:0][PFN_W-1:0] pfn_all;
    usage_t [ENTRIES-1:0]          use_all;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        logic [VPN_W-1:0] tag_q;
        logic [PFN_W-1:0] pfn_q;
        usage_t           use_q;

        assign match[g]     = use_q.valid && (tag_q == lk_vpn);
        assign valid_vec[g] = use_q.valid;
        assign tag_all[g]   = tag_q;
        assign pfn_all[g]   = pfn_q;
        assign use_all[g]   = use_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                tag_q <= '0;
                pfn_q <= '0;
                use_q <= '0;
            end else begin
                if (fill_en && (fill_idx == IDX_W'(g))) begin
                    tag_q <= fill_vpn;
                    pfn_q <= fill_pfn;
                    use_q <= '{valid: 1'b1, dirty: fill_dirty, refd: 1'b1};
                end else if (touch_en && match[g]) begin
                    use_q.refd <= 1'b1;
                    if (touch_write) begin
                        use_q.dirty <= 1'b1;
                    end
                end
                if (flush) begin
                    use_q.valid <= 1'b0;
                end
            end
        end
    end

    always_comb begin
        hit_pfn = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) begin
                hit_pfn = pfn_all[i];
            end
        end
    end

    assign hit     = |match;
    assign vic_vpn = tag_all[vic_idx];
    assign vic_use = use_all[vic_idx];

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim
    import tlb_pkg::*;
#(
    parameter int unsigned ENTRIES = DEF_ENTRIES,
    parameter int unsigned IDX_W   = idx_width(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ENTRIES-1:0] valid_vec,
    input  logic               advance,
    output logic [IDX_W-1:0]   vic_idx
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    logic [IDX_W-1:0] rr_q;
    logic [IDX_W-1:0] rr_next;
    logic [IDX_W-1:0] free_idx;
    logic             free_found;

    always_comb begin
        free_found = 1'b0;
        free_idx   = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!valid_vec[i]) begin
                free_found = 1'b1;
                free_idx   = IDX_W'(i);
            end
        end
    end

    if ((ENTRIES > 1) && ((ENTRIES & (ENTRIES - 1)) == 0)) begin : g_pow2
        assign rr_next = rr_q + 1'b1;
    end else begin : g_wrap
        assign rr_next = (rr_q == LAST) ? '0 : rr_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rr_q <= '0;
        end else if (advance && !free_found) begin
            rr_q <= rr_next;
        end
    end

    assign vic_idx = free_found ? free_idx : rr_q;

endmodule

// File: rtl/tlb_ctrl.sv
module tlb_ctrl
    import tlb_pkg::*;
#(
    parameter int unsigned VPN_W = DEF_VPN_W,
    parameter int unsigned OFF_W = DEF_OFF_W,
    parameter int unsigned PFN_W = DEF_PFN_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   req_valid,
    input  logic                   req_write,
    input  logic [VPN_W-1:0]       req_vpn,
    input  logic [OFF_W-1:0]       req_off,
    output logic                   req_ready,
    input  logic                   hit,
    input  logic [PFN_W-1:0]       hit_pfn,
    output logic                   touch_en,
    output logic                   touch_write,
    output logic                   fill_en,
    output logic [VPN_W-1:0]       fill_vpn,
    output logic [PFN_W-1:0]       fill_pfn,
    output logic                   fill_dirty,
    input  logic [VPN_W-1:0]       vic_vpn,
    input  usage_t                 vic_use,
    output logic                   pt_req,
    output logic [VPN_W-1:0]       pt_vpn,
    input  logic                   pt_valid,
    input  logic                   pt_present,
    input  logic [PFN_W-1:0]       pt_pfn,
    input  logic                   pt_dirty,
    output logic                   resp_valid,
    output logic                   resp_fault,
    output logic [PFN_W+OFF_W-1:0] resp_paddr,
    output logic                   wb_strobe,
    output logic [VPN_W-1:0]       wb_vpn,
    output logic                   wb_dirty,
    output logic                   wb_ref
);

    ctl_state_e       state_q;
    logic [VPN_W-1:0] vpn_q;
    logic [OFF_W-1:0] off_q;
    logic             wr_q;
    logic             accept;
    logic             walk_done;

    assign req_ready   = (state_q == CTL_IDLE);
    assign accept      = req_ready && req_valid;
    assign walk_done   = (state_q == CTL_WALK) && pt_valid;

    assign touch_en    = accept && hit;
    assign touch_write = req_write;

    assign fill_en     = walk_done && pt_present;
    assign fill_vpn    = vpn_q;
    assign fill_pfn    = pt_pfn;
    assign fill_dirty  = pt_dirty | wr_q;

    assign pt_req      = (state_q == CTL_WALK);
    assign pt_vpn      = vpn_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= CTL_IDLE;
            vpn_q      <= '0;
            off_q      <= '0;
            wr_q       <= 1'b0;
            resp_valid <= 1'b0;
            resp_fault <= 1'b0;
            resp_paddr <= '0;
            wb_strobe  <= 1'b0;
            wb_vpn     <= '0;
            wb_dirty   <= 1'b0;
            wb_ref     <= 1'b0;
        end else begin
            resp_valid <= 1'b0;
            resp_fault <= 1'b0;
            resp_paddr <= '0;
            wb_strobe  <= 1'b0;
            wb_vpn     <= '0;
            wb_dirty   <= 1'b0;
            wb_ref     <= 1'b0;
            unique case (state_q)
                CTL_IDLE: begin
                    if (accept) begin
                        if (hit) begin
                            resp_valid <= 1'b1;
                            resp_paddr <= {hit_pfn, req_off};
                        end else begin
                            state_q <= CTL_WALK;
                            vpn_q   <= req_vpn;
                            off_q   <= req_off;
                            wr_q    <= req_write;
                        end
                    end
                end
                CTL_WALK: begin
                    if (pt_valid) begin
                        state_q    <= CTL_IDLE;
                        resp_valid <= 1'b1;
                        if (pt_present) begin
                            resp_paddr <= {pt_pfn, off_q};
                            wb_strobe  <= vic_use.valid;
                            if (vic_use.valid) begin
                                wb_vpn   <= vic_vpn;
                                wb_dirty <= vic_use.dirty;
                                wb_ref   <= vic_use.refd;
                            end
                        end else begin
                            resp_fault <= 1'b1;
                        end
                    end
                end
                default: state_q <= CTL_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
    import tlb_pkg::*;
#(
    parameter int unsigned ENTRIES = DEF_ENTRIES,
    parameter int unsigned VPN_W   = DEF_VPN_W,
    parameter int unsigned OFF_W   = DEF_OFF_W,
    parameter int unsigned PFN_W   = DEF_PFN_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   flush_i,
    input  logic                   req_valid_i,
    output logic                   req_ready_o,
    input  logic                   req_write_i,
    input  logic [VPN_W+OFF_W-1:0] req_vaddr_i,
    output logic                   resp_valid_o,
    output logic                   resp_fault_o,
    output logic [PFN_W+OFF_W-1:0] resp_paddr_o,
    output logic                   pt_req_o,
    output logic [VPN_W-1:0]       pt_vpn_o,
    input  logic                   pt_valid_i,
    input  logic                   pt_present_i,
    input  logic [PFN_W-1:0]       pt_pfn_i,
    input  logic                   pt_dirty_i,
    output logic                   wb_strobe_o,
    output logic [VPN_W-1:0]       wb_vpn_o,
    output logic                   wb_dirty_o,
    output logic                   wb_ref_o
);

    localparam int unsigned IDX_W = idx_width(ENTRIES);

    logic [VPN_W-1:0]   req_vpn;
    logic [OFF_W-1:0]   req_off;
    logic               hit;
    logic [PFN_W-1:0]   hit_pfn;
    logic               touch_en;
    logic               touch_write;
    logic               fill_en;
    logic [VPN_W-1:0]   fill_vpn;
    logic [PFN_W-1:0]   fill_pfn;
    logic               fill_dirty;
    logic [IDX_W-1:0]   vic_idx;
    logic [VPN_W-1:0]   vic_vpn;
    usage_t             vic_use;
    logic [ENTRIES-1:0] valid_vec;

    assign req_vpn = req_vaddr_i[OFF_W +: VPN_W];
    assign req_off = req_vaddr_i[OFF_W-1:0];

    tlb_cam #(
        .ENTRIES (ENTRIES),
        .VPN_W   (VPN_W),
        .PFN_W   (PFN_W),
        .IDX_W   (IDX_W)
    ) u_cam (
        .clk         (clk),
        .rst         (rst),
        .flush       (flush_i),
        .lk_vpn      (req_vpn),
        .touch_en    (touch_en),
        .touch_write (touch_write),
        .hit         (hit),
        .hit_pfn     (hit_pfn),
        .fill_en     (fill_en),
        .fill_idx    (vic_idx),
        .fill_vpn    (fill_vpn),
        .fill_pfn    (fill_pfn),
        .fill_dirty  (fill_dirty),
        .vic_idx     (vic_idx),
        .vic_vpn     (vic_vpn),
        .vic_use     (vic_use),
        .valid_vec   (valid_vec)
    );

    tlb_victim #(
        .ENTRIES (ENTRIES),
        .IDX_W   (IDX_W)
    ) u_victim (
        .clk       (clk),
        .rst       (rst),
        .valid_vec (valid_vec),
        .advance   (fill_en),
        .vic_idx   (vic_idx)
    );

    tlb_ctrl #(
        .VPN_W (VPN_W),
        .OFF_W (OFF_W),
        .PFN_W (PFN_W)
    ) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid_i),
        .req_write   (req_write_i),
        .req_vpn     (req_vpn),
        .req_off     (req_off),
        .req_ready   (req_ready_o),
        .hit         (hit),
        .hit_pfn     (hit_pfn),
        .touch_en    (touch_en),
        .touch_write (touch_write),
        .fill_en     (fill_en),
        .fill_vpn    (fill_vpn),
        .fill_pfn    (fill_pfn),
        .fill_dirty  (fill_dirty),
        .vic_vpn     (vic_vpn),
        .vic_use     (vic_use),
        .pt_req      (pt_req_o),
        .pt_vpn      (pt_vpn_o),
        .pt_valid    (pt_valid_i),
        .pt_present  (pt_present_i),
        .pt_pfn      (pt_pfn_i),
        .pt_dirty    (pt_dirty_i),
        .resp_valid  (resp_valid_o),
        .resp_fault  (resp_fault_o),
        .resp_paddr  (resp_paddr_o),
        .wb_strobe   (wb_strobe_o),
        .wb_vpn      (wb_vpn_o),
        .wb_dirty    (wb_dirty_o),
        .wb_ref      (wb_ref_o)
    );

endmodule

// File: rtl/tlb_chk.sv
module tlb_chk #(
    parameter int unsigned ENTRIES = 8,
    parameter int unsigned VPN_W   = 20,
    parameter int unsigned OFF_W   = 12
) (
    input logic               clk,
    input logic               rst,
    input logic               flush,
    input logic               req_valid,
    input logic               req_ready,
    input logic [OFF_W-1:0]   req_off,
    input logic               resp_valid,
    input logic               resp_fault,
    input logic [OFF_W-1:0]   resp_off,
    input logic               pt_req,
    input logic [VPN_W-1:0]   pt_vpn,
    input logic               pt_valid,
    input logic               wb_strobe,
    input logic [ENTRIES-1:0] valid_vec
);

    AST_RESET_IDLE: assert property (@(posedge clk) rst |=> (req_ready && !resp_valid && !pt_req && !wb_strobe && (valid_vec == '0))); // R1

    AST_HIT_OR_WALK: assert property (@(posedge clk) disable iff (rst) (req_valid && req_ready) |=> (resp_valid != pt_req)); // R2

    AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (rst) (req_valid && req_ready) |=> (!resp_valid || (resp_off == $past(req_off)))); // R2

    AST_WALK_HOLD: assert property (@(posedge clk) disable iff (rst) (pt_req && !pt_valid) |=> (pt_req && $stable(pt_vpn))); // R3

    AST_WALK_BLOCKS: assert property (@(posedge clk) disable iff (rst) pt_req |-> !req_ready); // R3

    AST_WALK_ENDS: assert property (@(posedge clk) disable iff (rst) (pt_req && pt_valid) |=> (resp_valid && !pt_req)); // R4

    AST_FAULT_NO_FILL: assert property (@(posedge clk) disable iff (rst) (resp_fault && !$past(flush)) |-> (resp_valid && !wb_strobe && $stable(valid_vec))); // R5

    AST_EMPTY_FIRST: assert property (@(posedge clk) disable iff (rst) wb_strobe |-> (resp_valid && $past(&valid_vec))); // R7

    AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (rst) flush |=> (valid_vec == '0)); // R9

endmodule

bind tlb_xlate tlb_chk #(
    .ENTRIES (ENTRIES),
    .VPN_W   (VPN_W),
    .OFF_W   (OFF_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .flush      (flush_i),
    .req_valid  (req_valid_i),
    .req_ready  (req_ready_o),
    .req_off    (req_vaddr_i[OFF_W-1:0]),
    .resp_valid (resp_valid_o),
    .resp_fault (resp_fault_o),
    .resp_off   (resp_paddr_o[OFF_W-1:0]),
    .pt_req     (pt_req_o),
    .pt_vpn     (pt_vpn_o),
    .pt_valid   (pt_valid_i),
    .wb_strobe  (wb_strobe_o),
    .valid_vec  (valid_vec)
);

// File: tb/sim_tlb_xlate.sv
module sim_tlb_xlate;

    localparam int N     = 8;
    localparam int VPN_W = 20;
    localparam int OFF_W = 12;
    localparam int PFN_W = 20;

    logic                   clk = 1'b0;
    logic                   rst = 1'b1;
    logic                   flush_i = 1'b0;
    logic                   req_valid_i = 1'b0;
    logic                   req_ready_o;
    logic                   req_write_i = 1'b0;
    logic [VPN_W+OFF_W-1:0] req_vaddr_i = '0;
    logic                   resp_valid_o;
    logic                   resp_fault_o;
    logic [PFN_W+OFF_W-1:0] resp_paddr_o;
    logic                   pt_req_o;
    logic [VPN_W-1:0]       pt_vpn_o;
    logic                   pt_valid_i = 1'b0;
    logic                   pt_present_i = 1'b0;
    logic [PFN_W-1:0]       pt_pfn_i = '0;
    logic                   pt_dirty_i = 1'b0;
    logic                   wb_strobe_o;
    logic [VPN_W-1:0]       wb_vpn_o;
    logic                   wb_dirty_o;
    logic                   wb_ref_o;

    tlb_xlate u0 (
        .clk          (clk),
        .rst          (rst),
        .flush_i      (flush_i),
        .req_valid_i  (req_valid_i),
        .req_ready_o  (req_ready_o),
        .req_write_i  (req_write_i),
        .req_vaddr_i  (req_vaddr_i),
        .resp_valid_o (resp_valid_o),
        .resp_fault_o (resp_fault_o),
        .resp_paddr_o (resp_paddr_o),
        .pt_req_o     (pt_req_o),
        .pt_vpn_o     (pt_vpn_o),
        .pt_valid_i   (pt_valid_i),
        .pt_present_i (pt_present_i),
        .pt_pfn_i     (pt_pfn_i),
        .pt_dirty_i   (pt_dirty_i),
        .wb_strobe_o  (wb_strobe_o),
        .wb_vpn_o     (wb_vpn_o),
        .wb_dirty_o   (wb_dirty_o),
        .wb_ref_o     (wb_ref_o)
    );

    always #10 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    logic [VPN_W-1:0] m_vpn [N];
    bit               m_val [N];
    bit               m_dirty [N];
    bit               m_ref [N];
    int               m_rr = 0;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit tbl_present(input logic [VPN_W-1:0] v);
        return v[2:0] != 3'b111;
    endfunction

    function automatic logic [PFN_W-1:0] tbl_frame(input logic [VPN_W-1:0] v);
        return PFN_W'(v * 20'd3 + 20'h00A51);
    endfunction

    function automatic bit tbl_dirty(input logic [VPN_W-1:0] v);
        return v[4];
    endfunction

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush_i = 1'b1;
        @(negedge clk);
        flush_i = 1'b0;
        for (int i = 0; i < N; i++) m_val[i] = 1'b0;
        check("R9 ready after flush", 64'(req_ready_o), 64'd1);
    endtask

    task automatic do_access(input logic [VPN_W-1:0] vpn, input logic [OFF_W-1:0] off, input bit wr);
        int hi;
        int v;
        bit pres;
        hi = -1;
        for (int i = 0; i < N; i++) if (m_val[i] && m_vpn[i] == vpn) hi = i;
        @(negedge clk);
        check("R3 ready when idle", 64'(req_ready_o), 64'd1);
        req_valid_i = 1'b1;
        req_vaddr_i = {vpn, off};
        req_write_i = wr;
        @(negedge clk);
        req_valid_i = 1'b0;
        req_write_i = 1'b0;
        if (hi >= 0) begin
            check("R2 hit resp_valid", 64'(resp_valid_o), 64'd1);
            check("R2 hit paddr", 64'(resp_paddr_o), 64'({tbl_frame(vpn), off}));
            check("R2 hit no fault", 64'(resp_fault_o), 64'd0);
            check("R2 hit no table request", 64'(pt_req_o), 64'd0);
            m_ref[hi] = 1'b1;
            if (wr) m_dirty[hi] = 1'b1;
        end else begin
            check("R3 miss pt_req", 64'(pt_req_o), 64'd1);
            check("R3 miss pt_vpn", 64'(pt_vpn_o), 64'(vpn));
            check("R3 miss not ready", 64'(req_ready_o), 64'd0);
            check("R3 miss no response", 64'(resp_valid_o), 64'd0);
            @(negedge clk);
            check("R3 pt_req held", 64'(pt_req_o), 64'd1);
            check("R3 pt_vpn held", 64'(pt_vpn_o), 64'(vpn));
            pres = tbl_present(vpn);
            pt_valid_i   = 1'b1;
            pt_present_i = pres;
            pt_pfn_i     = tbl_frame(vpn);
            pt_dirty_i   = tbl_dirty(vpn);
            @(negedge clk);
            pt_valid_i   = 1'b0;
            pt_present_i = 1'b0;
            pt_pfn_i     = '0;
            pt_dirty_i   = 1'b0;
            check("R4 response after fill", 64'(resp_valid_o), 64'd1);
            check("R4 walk finished", 64'(pt_req_o), 64'd0);
            if (!pres) begin
                check("R5 fault flag", 64'(resp_fault_o), 64'd1);
                check("R5 no write-back on fault", 64'(wb_strobe_o), 64'd0);
            end else begin
                check("R4 no fault", 64'(resp_fault_o), 64'd0);
                check("R4 fill paddr", 64'(resp_paddr_o), 64'({tbl_frame(vpn), off}));
                v = -1;
                for (int i = N - 1; i >= 0; i--) if (!m_val[i]) v = i;
                if (v < 0) begin
                    v = m_rr;
                    check("R8 write-back strobe", 64'(wb_strobe_o), 64'd1);
                    check("R7 victim page", 64'(wb_vpn_o), 64'(m_vpn[v]));
                    check("R6 victim dirty", 64'(wb_dirty_o), 64'(m_dirty[v]));
                    check("R6 victim referenced", 64'(wb_ref_o), 64'(m_ref[v]));
                    m_rr = (m_rr + 1) % N;
                end else begin
                    check("R7 empty slot gives no write-back", 64'(wb_strobe_o), 64'd0);
                end
                m_vpn[v]   = vpn;
                m_val[v]   = 1'b1;
                m_ref[v]   = 1'b1;
                m_dirty[v] = tbl_dirty(vpn) | wr;
            end
        end
    endtask

    initial begin
        #(20ns * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        summary();
    end

    initial begin
        logic [31:0] r;
        int          idx;
        logic [VPN_W-1:0] pv;
        for (int i = 0; i < N; i++) begin
            m_vpn[i] = '0; m_val[i] = 1'b0; m_dirty[i] = 1'b0; m_ref[i] = 1'b0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 ready", 64'(req_ready_o), 64'd1);
        check("R1 resp_valid", 64'(resp_valid_o), 64'd0);
        check("R1 resp_fault", 64'(resp_fault_o), 64'd0);
        check("R1 pt_req", 64'(pt_req_o), 64'd0);
        check("R1 wb_strobe", 64'(wb_strobe_o), 64'd0);

        // R1 R7: fill every empty slot, lowest first, no write-backs
        for (int i = 0; i < N; i++) do_access(20'h01000 + VPN_W'(i * 16), OFF_W'(i * 12'h111), 1'b0);

        // R2 R6: hit sweep over offsets, some writes
        for (int i = 0; i < N; i++) begin
            do_access(20'h01000 + VPN_W'(i * 16), 12'h000, 1'b0);
            do_access(20'h01000 + VPN_W'(i * 16), 12'hFFF, (i % 3) == 0);
            do_access(20'h01000 + VPN_W'(i * 16), OFF_W'(i * 12'h155), 1'b0);
        end

        // R7 R8: evictions in round-robin order
        for (int i = 0; i < 10; i++) do_access(20'h02000 + VPN_W'(i * 16), OFF_W'(i * 12'h0AB), i[0]);

        // R5: not-present page faults twice and installs nothing
        do_access(20'h03007, 12'h123, 1'b0);
        do_access(20'h03007, 12'h456, 1'b1);
        do_access(20'h02090, 12'h777, 1'b0);

        // R9: flush then reload
        do_flush();
        do_access(20'h02090, 12'h001, 1'b1);
        for (int i = 0; i < N + 2; i++) do_access(20'h05000 + VPN_W'(i * 32), 12'h3C3, 1'b0);

        // mixed pseudo-random sweep
        r = 32'h1ACE_B00C;
        for (int k = 0; k < 300; k++) begin
            r = r ^ (r << 13);
            r = r ^ (r >> 17);
            r = r ^ (r << 5);
            idx = int'(r[3:0]);
            pv = 20'h04000 + VPN_W'(idx * 8) + ((idx == 5) ? 20'd7 : 20'd0);
            do_access(pv, r[17:6], r[20]);
            if (k == 150) do_flush();
        end

        repeat (2) @(negedge clk);
        summary();
    end

endmodule